// File: doc/BRIEF.md
# Power-Gated Mode Sequencer

This controller decides which datapath sections of a low-power sensing and irrigation chip receive supply, reset and a run command. After a global reset it first clears the two temperature memories by walking an address through every location with a write strobe held high. It then parks in standby with every section switched off. An hourly tick wakes only the hourly-update section. A daily tick wakes the daily-update and computation sections together, as one power domain. Each wake-up follows the same path: supply on, a fixed settling wait, a one-cycle reset of the section's adder, then a run phase that lasts until the section reports done, followed by a return to standby.

Ticks and done flags are single-bit control pulses with no handshake. A tick that arrives while the controller is busy, including during the memory clear, is remembered as one pending request per mode. When both requests are pending, hourly work is served first. Extra ticks of the same kind that arrive while a request is already pending merge into that one request.

Top module: `mode_seq_ctrl`

## Requirements
- R1: For the first 2^ADDR_W cycles after reset is released, `mem_clr_we` is high and `mem_clr_addr` counts up from 0 by one each cycle to its all-ones value. All power, reset and run outputs stay low during this phase, and `mem_clr_we` is low from then on.
- R2: In standby every power, reset and run output is low.
- R3: A pending hourly request taken in standby raises `hu_pwr` alone for exactly SETTLE_CYC cycles. `hu_rst` and `hu_pwr` are then high for one cycle. After that, `hu_run` and `hu_pwr` stay high until the cycle in which `hu_done` is sampled high.
- R4: A pending daily request follows the same sequence on `dc_pwr`, `dc_rst` and `dc_run`.
- R5: The cycle after a section's run phase ends, the controller is in standby and that section's power enable is low.
- R6: The daily run phase ends only once both `du_done` and `cp_done` have been sampled high during that run phase. The two may arrive in the same cycle or in different cycles.
- R7: A tick sampled high at a clock edge becomes pending at that edge. In standby, a pending hourly request is taken before a pending daily one, so when both ticks arrive together the hourly sequence runs first and the daily one runs after it.
- R8: A tick that arrives during the memory clear or during an active mode is held until the controller is back in standby, and is then served.
- R9: At most one of `hu_pwr` and `dc_pwr` is high in any cycle.
- R10: Done inputs sampled outside the matching run phase have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hour_tick | input | 1 | Hourly request pulse |
| day_tick | input | 1 | Daily request pulse |
| hu_done | input | 1 | Hourly-update section finished |
| du_done | input | 1 | Daily-update section finished |
| cp_done | input | 1 | Computation section finished |
| mem_clr_we | output | 1 | Write-zero strobe to both temperature memories |
| mem_clr_addr | output | ADDR_W | Address being cleared |
| hu_pwr | output | 1 | Hourly section supply enable |
| hu_rst | output | 1 | Hourly section adder reset |
| hu_run | output | 1 | Hourly section run enable |
| dc_pwr | output | 1 | Daily/computation supply enable |
| dc_rst | output | 1 | Daily/computation adder reset |
| dc_run | output | 1 | Daily/computation run enable |

## Verification
The bench builds the controller with ADDR_W=4 and SETTLE_CYC=3, not the defaults of 5 and 4. The shorter clear phase of 16 cycles lets the address wrap point, and ticks that land during the clear, come up often within the run. A settling count different from the default means that a hard-wired wait of four cycles shows up as a mismatch. Random pulse trains on the ticks and on all three done inputs, together with scripted coincident ticks, exercise request merging, hourly-first ordering and done pulses that land out of phase.

// File: rtl/mode_seq_pkg.sv
package mode_seq_pkg;
  typedef enum logic [2:0] {
    ST_CLEAR  = 3'd0,
    ST_IDLE   = 3'd1,
    ST_H_UP   = 3'd2,
    ST_H_RST  = 3'd3,
    ST_H_RUN  = 3'd4,
    ST_D_UP   = 3'd5,
    ST_D_RST  = 3'd6,
    ST_D_RUN  = 3'd7
  } seq_state_t;
endpackage

// File: rtl/clr_walker.sv
module clr_walker #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  localparam logic [ADDR_W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  addr <= '0;
    else if (en) addr <= addr + 1'b1;
  end

  assign last = en && (addr == TOP);
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_en,
  output logic expired
);
  localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!count_en) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  assign expired = count_en && (cnt == LAST);

  // R3
  cnt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_en |-> (cnt <= LAST));
endmodule

// File: rtl/req_latch.sv
module req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic take,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= tick | (pend & ~take);
  end
endmodule

// File: rtl/mode_seq_ctrl.sv
module mode_seq_ctrl
  import mode_seq_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hour_tick,
  input  logic              day_tick,
  input  logic              hu_done,
  input  logic              du_done,
  input  logic              cp_done,
  output logic              mem_clr_we,
  output logic [ADDR_W-1:0] mem_clr_addr,
  output logic              hu_pwr,
  output logic              hu_rst,
  output logic              hu_run,
  output logic              dc_pwr,
  output logic              dc_rst,
  output logic              dc_run
);
  seq_state_t state, nxt;
  logic clr_last, tmr_exp, pend_h, pend_d, take_h, take_d;
  logic du_seen, cp_seen, dc_finish;

  clr_walker #(.ADDR_W(ADDR_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .en(state == ST_CLEAR),
    .addr(mem_clr_addr), .last(clr_last));

  settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .count_en((state == ST_H_UP) || (state == ST_D_UP)),
    .expired(tmr_exp));

  assign take_h = (state == ST_IDLE) && pend_h;
  assign take_d = (state == ST_IDLE) && !pend_h && pend_d;

  req_latch u_hreq (.clk(clk), .rst_n(rst_n), .tick(hour_tick), .take(take_h), .pend(pend_h));
  req_latch u_dreq (.clk(clk), .rst_n(rst_n), .tick(day_tick),  .take(take_d), .pend(pend_d));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      du_seen <= 1'b0;
      cp_seen <= 1'b0;
    end else if (state == ST_D_RST) begin
      du_seen <= 1'b0;
      cp_seen <= 1'b0;
    end else if (state == ST_D_RUN) begin
      du_seen <= du_seen | du_done;
      cp_seen <= cp_seen | cp_done;
    end
  end

  assign dc_finish = (du_seen | du_done) & (cp_seen | cp_done);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_CLEAR: if (clr_last) nxt = ST_IDLE;
      ST_IDLE:  if (take_h) nxt = ST_H_UP;
                else if (take_d) nxt = ST_D_UP;
      ST_H_UP:  if (tmr_exp) nxt = ST_H_RST;
      ST_H_RST: nxt = ST_H_RUN;
      ST_H_RUN: if (hu_done) nxt = ST_IDLE;
      ST_D_UP:  if (tmr_exp) nxt = ST_D_RST;
      ST_D_RST: nxt = ST_D_RUN;
      ST_D_RUN: if (dc_finish) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_CLEAR;
    else        state <= nxt;
  end

  assign mem_clr_we = (state == ST_CLEAR);
  assign hu_pwr = (state == ST_H_UP) || (state == ST_H_RST) || (state == ST_H_RUN);
  assign hu_rst = (state == ST_H_RST);
  assign hu_run = (state == ST_H_RUN);
  assign dc_pwr = (state == ST_D_UP) || (state == ST_D_RST) || (state == ST_D_RUN);
  assign dc_rst = (state == ST_D_RST);
  assign dc_run = (state == ST_D_RUN);

  // R9
  one_domain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hu_pwr, dc_pwr}));

  // R1
  clear_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_clr_we |-> !(hu_pwr || dc_pwr));

  // R3
  hu_run_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hu_rst |=> hu_run);

  // R4
  dc_run_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dc_rst |=> dc_run);

  // R5
  hu_off_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hu_run && hu_done) |=> !hu_pwr);

  // R6
  dc_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_run && !du_done && !du_seen) |=> dc_pwr);
endmodule

// File: tb/tb_mode_seq_ctrl.sv
module tb_mode_seq_ctrl;
  localparam int PERIOD = 10;
  localparam int AW = 4;
  localparam int SC = 3;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hour_tick = 0, day_tick = 0, hu_done = 0, du_done = 0, cp_done = 0;
  logic mem_clr_we, hu_pwr, hu_rst, hu_run, dc_pwr, dc_rst, dc_run;
  logic [AW-1:0] mem_clr_addr;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  mode_seq_ctrl #(.ADDR_W(AW), .SETTLE_CYC(SC)) dut (
    .clk(clk), .rst_n(rst_n), .hour_tick(hour_tick), .day_tick(day_tick),
    .hu_done(hu_done), .du_done(du_done), .cp_done(cp_done),
    .mem_clr_we(mem_clr_we), .mem_clr_addr(mem_clr_addr),
    .hu_pwr(hu_pwr), .hu_rst(hu_rst), .hu_run(hu_run),
    .dc_pwr(dc_pwr), .dc_rst(dc_rst), .dc_run(dc_run));

  // reference model: phase 0 clear, 1 standby, 2 hourly, 3 daily
  // step within mode: 0..SC-1 power-up wait, SC adder reset, SC+1 running
  int m_phase = 0, m_step = 0, m_addr = 0;
  bit m_ph = 0, m_pd = 0, m_du = 0, m_cp = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_step = 0; m_addr = 0;
      m_ph = 0; m_pd = 0; m_du = 0; m_cp = 0;
    end else begin
      bit th, td;
      th = (m_phase == 1) && m_ph;          // R7 hourly wins
      td = (m_phase == 1) && !m_ph && m_pd;
      case (m_phase)
        0: begin
          if (m_addr == DEPTH - 1) m_phase = 1;
          m_addr = (m_addr + 1) % DEPTH;
        end
        1: begin
          if (th) begin m_phase = 2; m_step = 0; end
          else if (td) begin m_phase = 3; m_step = 0; end
        end
        2: begin
          if (m_step <= SC) m_step++;
          else if (hu_done) m_phase = 1;    // R5, R10 done only counts here
        end
        3: begin
          if (m_step < SC) m_step++;
          else if (m_step == SC) begin m_step++; m_du = 0; m_cp = 0; end
          else begin                        // R6 remember each done
            if (du_done) m_du = 1;
            if (cp_done) m_cp = 1;
            if (m_du && m_cp) m_phase = 1;
          end
        end
        default: m_phase = 1;
      endcase
      // R8 ticks held while busy
      m_ph = hour_tick | (m_ph & !th);
      m_pd = day_tick  | (m_pd & !td);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit e_hp, e_dp;
    e_hp = (m_phase == 2);
    e_dp = (m_phase == 3);
    chk("R1 clear strobe", mem_clr_we, m_phase == 0);
    if (m_phase == 0) chk("R1 clear addr", mem_clr_addr, m_addr);
    chk("R3 hu_pwr", hu_pwr, e_hp);
    chk("R3 hu_rst", hu_rst, e_hp && m_step == SC);
    chk("R3 hu_run", hu_run, e_hp && m_step == SC + 1);
    chk("R4 dc_pwr", dc_pwr, e_dp);
    chk("R4 dc_rst", dc_rst, e_dp && m_step == SC);
    chk("R4 dc_run", dc_run, e_dp && m_step == SC + 1);
    if (m_phase == 1) chk("R2 standby quiet", {hu_pwr, hu_rst, hu_run, dc_pwr, dc_rst, dc_run}, 0);
    chk("R9 single domain", (hu_pwr && dc_pwr), 0);
  endtask

  task automatic step(input bit h, input bit d, input bit hd, input bit dd, input bit cd);
    @(negedge clk);
    compare();
    hour_tick = h; day_tick = d; hu_done = hd; du_done = dd; cp_done = cd;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    // R8 daily tick during clear; R10 stray dones during clear
    step(0, 0, 1, 1, 1);
    step(0, 1, 0, 0, 0);
    for (int i = 0; i < DEPTH + 4; i++) step(0, 0, 0, 0, 0);
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);                    // finish the daily wake (R6 partial)
    step(0, 0, 0, 1, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0);                    // R7 coincident ticks
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 1);                    // R6 same-cycle dones
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0);
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom % 1000;
      step(r < 25, (r > 980), ($urandom % 6) == 0, ($urandom % 5) == 0, ($urandom % 7) == 0);
    end
    step(0, 0, 0, 0, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule